// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block is a bidirectional data path between an A side and a B side. It is split into `NUM_WORDS` independent words of `WORD_W` bits each, which by default gives two 8-bit words. Each word has one storage path per direction. That path can be transparent, can hold a captured value, or can load on a rising edge of a transfer clock that is shared by all words and both directions. Every word and every direction has its own active-low output enable. A global active-low enable switches off every output at once.

The design is synchronous to a system clock `clk`, which must run faster than the transfer clock `xfer_clk`. The block samples `xfer_clk` on `clk` and treats a 0-to-1 change between two samples as a transfer edge. Each bus is split into an input, an output value and a per-word drive enable, so the pad ring or the tristate logic can sit outside the block.

If both directions of one word are enabled in the same cycle, the block reports the clash on a per-word flag and drives neither side of that word.

Top module: `ubt_xcvr`

## Requirements
- R1: While `le_ab[w]` is 1, word w of `b_out` equals word w of `a_in` in the same cycle, with no register in between.
- R2: When `le_ab[w]` is 0 and was 1 at the previous `clk` edge, word w of `b_out` shows the `a_in` word sampled at that edge. This holds whatever level `xfer_clk` has.
- R3: While `le_ab[w]` is 0, a `clk` edge where `xfer_clk` samples 1 after sampling 0 at the edge before loads the `a_in` word. The `b_out` word shows the new value from that edge on.
- R4: While `le_ab[w]` is 0 and no transfer edge occurs, the `b_out` word keeps its value whatever `a_in` does.
- R5: With `oe_all_n`=0 and no clash, `b_oe[w]` is 1 exactly when `oe_ab_n[w]`=0, and `a_oe[w]` is 1 exactly when `oe_ba_n[w]`=0.
- R6: The B-to-A path obeys R1 to R4 with `le_ba`, `b_in` and `a_out` in place of `le_ab`, `a_in` and `b_out`.
- R7: While `oe_all_n` is 1, every bit of `a_oe` and `b_oe` is 0, whatever the per-word enables are.
- R8: When `oe_ab_n[w]` and `oe_ba_n[w]` are both 0 with `oe_all_n`=0, `word_conflict[w]` is 1 and both `a_oe[w]` and `b_oe[w]` are 0. Otherwise `word_conflict[w]` is 0.
- R9: While `rst` is 1, all enables out are 0. After reset, every storage path holds zero.
- R10: Words are independent. One word can be transparent while another holds, and each follows only its own latch enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_clk | input | 1 | Shared transfer clock, sampled on clk |
| a_in | input | WORD_W*NUM_WORDS | A-side data in |
| b_in | input | WORD_W*NUM_WORDS | B-side data in |
| le_ab | input | NUM_WORDS | Per-word A-to-B latch enable, 1 = transparent |
| le_ba | input | NUM_WORDS | Per-word B-to-A latch enable, 1 = transparent |
| oe_ab_n | input | NUM_WORDS | Per-word A-to-B output enable, active low |
| oe_ba_n | input | NUM_WORDS | Per-word B-to-A output enable, active low |
| oe_all_n | input | 1 | Global output enable, active low |
| a_out | output | WORD_W*NUM_WORDS | Value for the A side |
| a_oe | output | NUM_WORDS | Per-word drive enable for the A side |
| b_out | output | WORD_W*NUM_WORDS | Value for the B side |
| b_oe | output | NUM_WORDS | Per-word drive enable for the B side |
| word_conflict | output | NUM_WORDS | Per-word flag for both directions enabled |

## Verification
Some rules hold on every cycle, and the assertions check those: hold without an edge, capture on latch close, load on a transfer edge, no dual drive of one word, the global switch-off, and quiet enables during reset. Other behaviour shows only in the bench's sweep. It walks every combination of latch enables, output enables, global enable and transfer clock level over three data passes. That sweep is what shows the actual data values, which value a path picks after a mix of closes and edges, the per-word enable decode, and independence between words.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_CLOCK = 2'd1,
    MODE_HOLD  = 2'd2
  } path_mode_e;

  function automatic path_mode_e pick_mode(input logic le, input logic edge_seen);
    if (le)             return MODE_PASS;
    else if (edge_seen) return MODE_CLOCK;
    else                return MODE_HOLD;
  endfunction

endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  import ubt_pkg::*;

  path_mode_e       mode;
  logic [WIDTH-1:0] held;

  assign mode = pick_mode(le, load);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else begin
      case (mode)
        MODE_PASS, MODE_CLOCK: held <= d;
        default:               held <= held;
      endcase
    end
  end

  assign q = (mode == MODE_PASS) ? d : held;

  // Latch closing: the value seen while transparent stays.
  assert_close_capture_R2: assert property (@(posedge clk) disable iff (rst)
    le |=> (le || q == $past(d)));

  assert_clock_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!le && load) |=> (le || q == $past(d)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!le && !load) |=> (le || q == $past(q)));
endmodule

// File: rtl/ubt_word.sv
module ubt_word #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             le_ab,
  input  logic             le_ba,
  input  logic             oe_ab_n,
  input  logic             oe_ba_n,
  input  logic             oe_all_n,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_oe,
  output logic             b_oe,
  output logic             conflict
);
  logic want_ab;
  logic want_ba;

  ubt_store #(.WIDTH(WIDTH)) u_ab (
    .clk(clk), .rst(rst), .le(le_ab), .load(load), .d(a_in), .q(b_out)
  );

  ubt_store #(.WIDTH(WIDTH)) u_ba (
    .clk(clk), .rst(rst), .le(le_ba), .load(load), .d(b_in), .q(a_out)
  );

  always_comb begin
    want_ab  = ~oe_all_n & ~oe_ab_n;
    want_ba  = ~oe_all_n & ~oe_ba_n;
    conflict = want_ab & want_ba;
    b_oe     = want_ab & ~conflict & ~rst;
    a_oe     = want_ba & ~conflict & ~rst;
  end

  assert_no_dual_drive_R8: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  assert_clash_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (!a_oe && !b_oe));
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 2,
  localparam int BUS_W    = WORD_W * NUM_WORDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xfer_clk,
  input  logic [BUS_W-1:0]     a_in,
  input  logic [BUS_W-1:0]     b_in,
  input  logic [NUM_WORDS-1:0] le_ab,
  input  logic [NUM_WORDS-1:0] le_ba,
  input  logic [NUM_WORDS-1:0] oe_ab_n,
  input  logic [NUM_WORDS-1:0] oe_ba_n,
  input  logic                 oe_all_n,
  output logic [BUS_W-1:0]     a_out,
  output logic [NUM_WORDS-1:0] a_oe,
  output logic [BUS_W-1:0]     b_out,
  output logic [NUM_WORDS-1:0] b_oe,
  output logic [NUM_WORDS-1:0] word_conflict
);
  logic xfer_rise;

  ubt_edge_det u_edge (
    .clk(clk), .rst(rst), .lvl(xfer_clk), .rise(xfer_rise)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    ubt_word #(.WIDTH(WORD_W)) u_word (
      .clk      (clk),
      .rst      (rst),
      .load     (xfer_rise),
      .a_in     (a_in[w*WORD_W +: WORD_W]),
      .b_in     (b_in[w*WORD_W +: WORD_W]),
      .le_ab    (le_ab[w]),
      .le_ba    (le_ba[w]),
      .oe_ab_n  (oe_ab_n[w]),
      .oe_ba_n  (oe_ba_n[w]),
      .oe_all_n (oe_all_n),
      .a_out    (a_out[w*WORD_W +: WORD_W]),
      .b_out    (b_out[w*WORD_W +: WORD_W]),
      .a_oe     (a_oe[w]),
      .b_oe     (b_oe[w]),
      .conflict (word_conflict[w])
    );
  end

  assert_global_off_R7: assert property (@(posedge clk) disable iff (rst)
    oe_all_n |-> (a_oe == '0 && b_oe == '0));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |-> (a_oe == '0 && b_oe == '0));
endmodule

// File: tb/ubt_xcvr_bench.sv
module ubt_xcvr_bench;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int BW = W * N;

  logic          clk = 1'b0;
  logic          rst;
  logic          xfer_clk;
  logic [BW-1:0] a_in, b_in, a_out, b_out;
  logic [N-1:0]  le_ab, le_ba, oe_ab_n, oe_ba_n;
  logic          oe_all_n;
  logic [N-1:0]  a_oe, b_oe, word_conflict;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_ab [N];
  logic [W-1:0] m_ba [N];
  logic [N-1:0] ple_ab, ple_ba;
  logic         xprev, rose;

  always #5 clk = ~clk;

  ubt_xcvr #(.WORD_W(W), .NUM_WORDS(N)) u_ubt_xcvr (
    .clk(clk), .rst(rst), .xfer_clk(xfer_clk), .a_in(a_in), .b_in(b_in),
    .le_ab(le_ab), .le_ba(le_ba), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
    .oe_all_n(oe_all_n), .a_out(a_out), .a_oe(a_oe), .b_out(b_out),
    .b_oe(b_oe), .word_conflict(word_conflict)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] lab, input logic [N-1:0] lba,
                      input logic [N-1:0] oab, input logic [N-1:0] oba,
                      input logic oall, input logic xc,
                      input logic [BW-1:0] ad, input logic [BW-1:0] bd);
    logic rise;
    @(negedge clk);
    le_ab = lab; le_ba = lba; oe_ab_n = oab; oe_ba_n = oba;
    oe_all_n = oall; xfer_clk = xc; a_in = ad; b_in = bd;
    #1;
    for (int w = 0; w < N; w++) begin
      logic en_ab, en_ba, cf;
      logic [W-1:0] eb, ea;
      en_ab = !oall && !oab[w];
      en_ba = !oall && !oba[w];
      cf    = en_ab && en_ba;
      chk("R8", word_conflict[w], cf);
      chk(oall ? "R7" : "R5", b_oe[w], en_ab && !cf);
      chk(oall ? "R7" : "R5", a_oe[w], en_ba && !cf);
      eb = lab[w] ? ad[w*W +: W] : m_ab[w];
      ea = lba[w] ? bd[w*W +: W] : m_ba[w];
      chk(lab[w] ? "R1" : ple_ab[w] ? "R2" : rose ? "R3" : "R4",
          b_out[w*W +: W], eb);
      chk("R6", a_out[w*W +: W], ea);
    end
    @(posedge clk);
    rise = xc && !xprev;
    for (int w = 0; w < N; w++) begin
      if (lab[w] || rise) m_ab[w] = ad[w*W +: W];
      if (lba[w] || rise) m_ba[w] = bd[w*W +: W];
    end
    ple_ab = lab; ple_ba = lba; rose = rise; xprev = xc;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; xfer_clk = 1'b0; le_ab = '0; le_ba = '0;
    oe_ab_n = 2'b00; oe_ba_n = 2'b10; oe_all_n = 1'b0;
    a_in = 16'hA5C3; b_in = 16'h3C5A;
    for (int k = 0; k < N; k++) begin m_ab[k] = '0; m_ba[k] = '0; end
    ple_ab = '0; ple_ba = '0; xprev = 1'b0; rose = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", a_oe, 2'b00);
    chk("R9", b_oe, 2'b00);
    rst = 1'b0;
    oe_ab_n = '1; oe_ba_n = '1;
    #1;
    chk("R9", b_out, 16'h0000);
    chk("R9", a_out, 16'h0000);

    // R10: word 0 transparent while word 1 holds
    step(2'b11, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0, 16'h5566, 16'h0);
    step(2'b01, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0, 16'h2211, 16'h0);
    step(2'b01, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0, 16'h4433, 16'h0);
    @(negedge clk); #1;
    chk("R10", b_out[15:8], 8'h55);
    chk("R10", b_out[7:0], 8'h33);

    // Exhaustive sweep over control combinations, three data passes
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 1024; i++) begin
        logic [9:0] c;
        logic [BW-1:0] ad, bd;
        c  = i[9:0];
        ad = BW'(i * 16'h9E37) ^ BW'(pass * 16'h1357);
        bd = BW'(i * 16'h3C5B) + BW'(pass);
        step(c[2:1], c[4:3], c[6:5], c[8:7], c[9],
             c[0] ^ pass[0], ad, bd);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule